// File: doc/BRIEF.md
# Frame-rate speed detector

This block works out which speed range an incoming audio frame clock belongs to when the converter receives its clocks from outside. It counts how many cycles of the internal master clock occur in one frame period and maps that count to one of three speed codes. The internal master clock is the one that comes after the configurable pre-dividers, not the raw external clock. Because of this, no speed setting has to be written when the sample rate changes.

The pre-divided clock reaches the block as a one-cycle enable on the system clock. The frame clock may be asynchronous. It passes through a two-flop synchroniser, and each period is measured from one rising edge to the next. A count is accepted only if it lies close to a nominal ratio. Two consecutive frames must fall in the same range before a new code is committed, so that single glitched frames are filtered out. Counts that are out of range, and a frame clock that stops, both raise an error flag.

Top module: `speed_autodetect`

## Requirements
- R1: While reset is active and after it is released, speed_code is 00, speed_valid is 0 and ratio_err is 0, until the first qualified detection.
- R2: A period of 256 enable cycles, within ±4, is classified as single speed, speed_code 00.
- R3: A period of 128 enable cycles, within ±4, is classified as double speed, speed_code 01.
- R4: A period of 64 enable cycles, within ±4, is classified as quad speed, speed_code 10. Code 11 is never output while speed_valid is high.
- R5: The first rising frame edge after reset only starts a measurement. A code is committed, and speed_valid set, only when two consecutive measured periods give the same class. After the first commit, speed_valid stays high.
- R6: A measured period outside every tolerance window sets ratio_err and leaves speed_code and speed_valid unchanged. ratio_err clears at the next commit.
- R7: The period counter saturates at 511. Once it is saturated, ratio_err is set. A stopped frame clock therefore gives an error and never a wrapped count.
- R8: When the frame rate changes, speed_code follows without any mode input, after two periods at the new rate.
- R9: Only cycles with mclk_en high are counted. With mclk_en high on every second cycle, a frame of 512 system clocks is classified as single speed.
- R10: The window edges are inclusive. A count of 260 or 252 is accepted as single speed, and a count of 261 or 251 sets ratio_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_en | input | 1 | One-cycle pulse per internal (pre-divided) master clock |
| frame_clk | input | 1 | Asynchronous incoming frame clock |
| speed_code | output | 2 | 00 single, 01 double, 10 quad |
| speed_valid | output | 1 | A speed code has been qualified |
| ratio_err | output | 1 | Unsupported ratio or missing frame clock |

## Verification
The assertions check on every cycle that:
- no illegal code appears while speed_valid is high;
- speed_valid, once set, never drops;
- the code changes only after a synchronised frame edge;
- the period counter holds at saturation, and saturation always brings the error flag.

Only the directed scenarios can show the rest:
- the classification at each nominal ratio and at the inclusive window edges;
- the two-frame filter;
- tracking of a rate change;
- counting that depends on the enable.

// File: rtl/speed_autodetect.sv
module speed_autodetect #(
  parameter int RATIO_SINGLE = 256,
  parameter int TOL          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_en,
  input  logic       frame_clk,
  output logic [1:0] speed_code,
  output logic       speed_valid,
  output logic       ratio_err
);

  localparam int CNT_W = $clog2(2 * RATIO_SINGLE);
  localparam int M_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [M_W-1:0] S_LO = M_W'(RATIO_SINGLE - TOL);
  localparam logic [M_W-1:0] S_HI = M_W'(RATIO_SINGLE + TOL);
  localparam logic [M_W-1:0] D_LO = M_W'(RATIO_SINGLE / 2 - TOL);
  localparam logic [M_W-1:0] D_HI = M_W'(RATIO_SINGLE / 2 + TOL);
  localparam logic [M_W-1:0] Q_LO = M_W'(RATIO_SINGLE / 4 - TOL);
  localparam logic [M_W-1:0] Q_HI = M_W'(RATIO_SINGLE / 4 + TOL);

  logic [2:0]       fs_q;
  logic             fs_rise;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [M_W-1:0]   meas;
  logic             hit;
  logic [1:0]       cls;
  logic [1:0]       cand;
  logic             cand_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= '0;
    else        fs_q <= {fs_q[1:0], frame_clk};
  end

  assign fs_rise = fs_q[1] & ~fs_q[2];
  assign meas    = {1'b0, cnt} + M_W'(mclk_en);

  always_comb begin
    hit = 1'b1;
    cls = 2'b00;
    if (meas >= S_LO && meas <= S_HI)      cls = 2'b00;
    else if (meas >= D_LO && meas <= D_HI) cls = 2'b01;
    else if (meas >= Q_LO && meas <= Q_HI) cls = 2'b10;
    else                                   hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= armed | fs_rise;
      if (fs_rise)                      cnt <= '0;
      else if (mclk_en && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_code  <= 2'b00;
      speed_valid <= 1'b0;
      ratio_err   <= 1'b0;
      cand        <= 2'b00;
      cand_ok     <= 1'b0;
    end else if (armed && fs_rise) begin
      if (hit) begin
        cand    <= cls;
        cand_ok <= 1'b1;
        if (cand_ok && cand == cls) begin
          speed_code  <= cls;
          speed_valid <= 1'b1;
          ratio_err   <= 1'b0;
        end
      end else begin
        ratio_err <= 1'b1;
        cand_ok   <= 1'b0;
      end
    end else if (armed && cnt == CNT_MAX) begin
      ratio_err <= 1'b1;
      cand_ok   <= 1'b0;
    end
  end

  // R4
  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    speed_valid |-> speed_code != 2'b11);

  // R5
  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(speed_valid) |-> speed_valid);

  // R5
  a_r5_valid_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speed_valid) |-> $past(fs_rise));

  // R8
  a_r8_code_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rise |=> $stable(speed_code));

  // R7
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !fs_rise) |=> cnt == CNT_MAX);

  // R7
  a_r7_sat_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == CNT_MAX) |=> ratio_err);

endmodule

// File: tb/test_speed_autodetect.sv
module test_speed_autodetect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mclk_en = 1'b0;
  logic       frame_clk = 1'b0;
  logic [1:0] speed_code;
  logic       speed_valid;
  logic       ratio_err;
  int         en_div = 1;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) mclk_en <= (en_div == 1) ? 1'b1 : ~mclk_en;

  speed_autodetect i_speed_autodetect (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .frame_clk(frame_clk),
    .speed_code(speed_code), .speed_valid(speed_valid), .ratio_err(ratio_err)
  );

  task automatic check(input string req, input logic [1:0] code, input logic vld,
                       input logic err, input logic [1:0] e_code, input logic e_vld,
                       input logic e_err);
    n_chk++;
    if (code !== e_code || vld !== e_vld || err !== e_err) begin
      n_bad++;
      $display("FAIL %s: code/valid/err = %b/%b/%b, expected %b/%b/%b",
               req, code, vld, err, e_code, e_vld, e_err);
    end
  endtask

  task automatic frames(input int period, input int n);
    for (int f = 0; f < n; f++) begin
      frame_clk = 1'b1;
      repeat (period / 2) @(negedge clk);
      frame_clk = 1'b0;
      repeat (period - period / 2) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_clk = 1'b0;
    en_div = 1;
    repeat (4) @(negedge clk);
    check("R1 in reset", speed_code, speed_valid, ratio_err, 2'b00, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", speed_code, speed_valid, ratio_err, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_filter_single();
    do_reset();
    frames(256, 2);
    check("R5 one period not enough", speed_code, speed_valid, ratio_err, 2'b00, 1'b0, 1'b0);
    frames(256, 1);
    check("R2 single committed", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
  endtask

  task automatic t_rate_change();
    frames(128, 2);
    check("R8 one period after change", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
    frames(128, 1);
    check("R3 double committed", speed_code, speed_valid, ratio_err, 2'b01, 1'b1, 1'b0);
    frames(64, 3);
    check("R4 quad committed", speed_code, speed_valid, ratio_err, 2'b10, 1'b1, 1'b0);
    frames(256, 3);
    check("R8 back to single", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
  endtask

  task automatic t_edges();
    frames(260, 1);
    frames(252, 1);
    frames(256, 1);
    check("R10 260 and 252 accepted", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
    frames(261, 1);
    frames(256, 1);
    check("R10 261 rejected, R6 code kept", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b1);
    frames(256, 2);
    check("R6 err cleared on commit", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
    frames(251, 1);
    frames(256, 1);
    check("R10 251 rejected", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b1);
    frames(256, 2);
    frames(200, 1);
    frames(256, 1);
    check("R6 unsupported ratio 200", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b1);
  endtask

  task automatic t_missing();
    frames(64, 4);
    check("R4 quad before stop", speed_code, speed_valid, ratio_err, 2'b10, 1'b1, 1'b0);
    frame_clk = 1'b0;
    repeat (600) @(negedge clk);
    check("R7 stopped frame clock", speed_code, speed_valid, ratio_err, 2'b10, 1'b1, 1'b1);
    frames(64, 3);
    check("R7 recovery", speed_code, speed_valid, ratio_err, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_enable();
    do_reset();
    en_div = 2;
    frames(512, 4);
    check("R9 enable-gated single", speed_code, speed_valid, ratio_err, 2'b00, 1'b1, 1'b0);
    frames(256, 3);
    check("R9 enable-gated double", speed_code, speed_valid, ratio_err, 2'b01, 1'b1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_filter_single();
    t_rate_change();
    t_edges();
    t_missing();
    t_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule